// File: doc/BRIEF.md
# Receive Polarity Detect and Correct

This block corrects a swapped receive wire pair on the 10 Mb/s receive path and the link pulses used during speed negotiation. It sits after the slicer and before the Manchester decoder. Each sliced serial bit passes through an XOR with the current inversion state. An inversion change takes effect only in a cycle with no frame in progress, so a frame is never decoded with mixed polarity.

In automatic mode the block forms its own view of the line. Every link-pulse strobe and every end-of-frame strobe comes with a sign that says whether the raw waveform looked reversed. When `THRESH` reports of the same sign arrive in a row, the block decides on that polarity. In manual mode, software sets the inversion directly through the same register bit that reports status in automatic mode.

The register interface has two bits: bit 1 selects the mode and bit 0 holds the polarity. When software moves the block from manual back to automatic mode, the manually set polarity stays in force until the detector reaches its next decision.

Top module: `rx_polarity_fix`

## Requirements
- R1: After reset the mode is automatic, `regRdData` reads 2'b00, `polInverted` is 0 and `rxBitFixed` equals `rxBit`.
- R2: In automatic mode, `THRESH` (default 2) consecutive reversed reports make `regRdData[0]` read 1 in the cycle after the last of those strobes. A reversed report is `lpStrobe` with `lpNeg`=1, or `eofStrobe` with `eofInv`=1.
- R3: In automatic mode, `THRESH` consecutive normal reports make `regRdData[0]` read 0. A report of the opposite sign restarts the run.
- R4: Link-pulse and end-of-frame reports count toward the same run and may be mixed. When both strobes occur in one cycle, only the link-pulse sign is used.
- R5: A write with bit 1 = 1 selects manual mode, and bit 0 of that write sets the inversion. `regRdData` then returns the written value.
- R6: In manual mode, report strobes have no effect on the polarity.
- R7: In automatic mode, bit 0 of a write is ignored.
- R8: After a write that returns the block from manual to automatic mode, the manual polarity holds until `THRESH` reports of one sign have arrived after the switch.
- R9: `rxBitFixed` is `rxBit` XOR the applied inversion. The applied inversion copies the decided polarity only at an edge where `rxInFrame` is low, so a decision made during a frame takes effect one edge after `rxInFrame` falls.
- R10: `polInverted` shows the applied inversion. It lags the register read-back by one edge while no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxBit | input | 1 | Sliced serial receive bit |
| rxInFrame | input | 1 | High while a frame is being received |
| lpStrobe | input | 1 | One-cycle link-pulse seen |
| lpNeg | input | 1 | Link pulse looked negative-going |
| eofStrobe | input | 1 | One-cycle end-of-frame seen |
| eofInv | input | 1 | End-of-frame pattern looked inverted |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 2 | Write data: bit 1 mode (1 manual), bit 0 polarity |
| regRdData | output | 2 | Read data: bit 1 mode, bit 0 decided polarity |
| rxBitFixed | output | 1 | Polarity-corrected serial bit |
| polInverted | output | 1 | Inversion currently applied to the data |

## Verification
Every sign sequence of six reports, alternating between link-pulse and end-of-frame strobes, is applied from reset. The expected polarity is computed from run lengths, which separates a correct run counter from one that fails to restart or that decides one report early or late. Directed patterns then present strobes in the same cycle with opposing signs, manual writes, reports that arrive while in manual mode, and the switch back to automatic mode. Each of these isolates one ownership rule of bit 0. A decision made during a frame shows whether the applied inversion waits for the frame to end.

// File: rtl/rxpol_pkg.sv
package rxpol_pkg;
  typedef struct packed {
    logic setInv;
    logic clrInv;
  } polCmd_t;
endpackage

// File: rtl/rxpol_ctrl.sv
module rxpol_ctrl #(
  parameter int THRESH = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic lpStrobe,
  input  logic lpNeg,
  input  logic eofStrobe,
  input  logic eofInv,
  input  logic regWrEn,
  input  logic [1:0] regWrData,
  output logic modeManual,
  output rxpol_pkg::polCmd_t cmd
);
  localparam int CNT_W = (THRESH < 2) ? 1 : $clog2(THRESH);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(THRESH - 1);

  logic [CNT_W-1:0] revCnt, normCnt;
  logic evValid, evRev;

  assign evValid = lpStrobe | eofStrobe;
  assign evRev   = lpStrobe ? lpNeg : eofInv;

  always_comb begin
    cmd = '0;
    if (regWrEn) begin
      if (regWrData[1]) begin
        cmd.setInv = regWrData[0];
        cmd.clrInv = ~regWrData[0];
      end
    end else if (!modeManual && evValid) begin
      if (evRev && revCnt == LAST) cmd.setInv = 1'b1;
      if (!evRev && normCnt == LAST) cmd.clrInv = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeManual <= 1'b0;
      revCnt     <= '0;
      normCnt    <= '0;
    end else begin
      if (regWrEn) modeManual <= regWrData[1];
      if (modeManual || regWrEn) begin
        revCnt  <= '0;
        normCnt <= '0;
      end else if (evValid) begin
        if (evRev) begin
          normCnt <= '0;
          revCnt  <= (revCnt == LAST) ? '0 : revCnt + 1'b1;
        end else begin
          revCnt  <= '0;
          normCnt <= (normCnt == LAST) ? '0 : normCnt + 1'b1;
        end
      end
    end
  end

  // R5
  mode_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> modeManual == $past(regWrData[1]));
  // R6
  manual_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeManual && !regWrEn) |-> !(cmd.setInv || cmd.clrInv));
  // R3
  run_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (revCnt <= LAST) && (normCnt <= LAST) && !(revCnt != '0 && normCnt != '0));
endmodule

// File: rtl/rxpol_path.sv
module rxpol_path (
  input  logic clk,
  input  logic rstN,
  input  rxpol_pkg::polCmd_t cmd,
  input  logic rxInFrame,
  input  logic rxBit,
  output logic polPending,
  output logic polApplied,
  output logic rxBitFixed
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      polPending <= 1'b0;
      polApplied <= 1'b0;
    end else begin
      if (cmd.setInv)      polPending <= 1'b1;
      else if (cmd.clrInv) polPending <= 1'b0;
      if (!rxInFrame) polApplied <= polPending;
    end
  end

  assign rxBitFixed = rxBit ^ polApplied;

  // R9
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxInFrame |=> $stable(polApplied));
  // R7
  pending_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.setInv || cmd.clrInv) |=> $stable(polPending));
endmodule

// File: rtl/rx_polarity_fix.sv
module rx_polarity_fix #(
  parameter int THRESH = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxBit,
  input  logic       rxInFrame,
  input  logic       lpStrobe,
  input  logic       lpNeg,
  input  logic       eofStrobe,
  input  logic       eofInv,
  input  logic       regWrEn,
  input  logic [1:0] regWrData,
  output logic [1:0] regRdData,
  output logic       rxBitFixed,
  output logic       polInverted
);
  rxpol_pkg::polCmd_t cmd;
  logic modeManual, polPending, polApplied;

  rxpol_ctrl #(.THRESH(THRESH)) uCtrl (
    .clk(clk), .rstN(rstN),
    .lpStrobe(lpStrobe), .lpNeg(lpNeg),
    .eofStrobe(eofStrobe), .eofInv(eofInv),
    .regWrEn(regWrEn), .regWrData(regWrData),
    .modeManual(modeManual), .cmd(cmd)
  );

  rxpol_path uPath (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .rxInFrame(rxInFrame), .rxBit(rxBit),
    .polPending(polPending), .polApplied(polApplied),
    .rxBitFixed(rxBitFixed)
  );

  assign regRdData   = {modeManual, polPending};
  assign polInverted = polApplied;
endmodule

// File: tb/rx_polarity_fix_test.sv
module rx_polarity_fix_test;
  localparam int THRESH = 2;
  logic clk = 1'b0, rstN = 1'b0, rxBit = 1'b0, rxInFrame = 1'b0;
  logic lpStrobe = 1'b0, lpNeg = 1'b0, eofStrobe = 1'b0, eofInv = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regWrData = 2'b00;
  logic [1:0] regRdData;
  logic rxBitFixed, polInverted;
  int nChecks = 0, nFail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rx_polarity_fix #(.THRESH(THRESH)) uut (
    .clk(clk), .rstN(rstN), .rxBit(rxBit), .rxInFrame(rxInFrame),
    .lpStrobe(lpStrobe), .lpNeg(lpNeg), .eofStrobe(eofStrobe), .eofInv(eofInv),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .rxBitFixed(rxBitFixed), .polInverted(polInverted)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chkFix(input logic inv, input string tag);
    rxBit = 1'b0; #1;
    chk(rxBitFixed == inv, tag, int'(rxBitFixed), int'(inv));
    rxBit = 1'b1; #1;
    chk(rxBitFixed == !inv, tag, int'(rxBitFixed), int'(!inv));
    rxBit = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic evid(input bit isLp, input bit sign);
    if (isLp) begin lpStrobe = 1'b1; lpNeg = sign; end
    else begin eofStrobe = 1'b1; eofInv = sign; end
    @(negedge clk);
    lpStrobe = 1'b0; eofStrobe = 1'b0; lpNeg = 1'b0; eofInv = 1'b0;
  endtask

  task automatic evBoth(input bit lpSign, input bit eofSign);
    lpStrobe = 1'b1; lpNeg = lpSign; eofStrobe = 1'b1; eofInv = eofSign;
    @(negedge clk);
    lpStrobe = 1'b0; eofStrobe = 1'b0; lpNeg = 1'b0; eofInv = 1'b0;
  endtask

  task automatic regWr(input logic [1:0] d);
    regWrEn = 1'b1; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = 2'b00;
  endtask

  initial begin
    #3000000;
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1 reset state
    chk(regRdData == 2'b00, "R1 regRdData", int'(regRdData), 0);
    chk(polInverted == 1'b0, "R1 polInverted", int'(polInverted), 0);
    chkFix(1'b0, "R1 rxBitFixed");

    // R2 R3 R4 R10: sweep every six-report sign pattern
    for (int pat = 0; pat < 64; pat++) begin
      logic pol;
      logic last;
      int run;
      doReset();
      pol = 1'b0; last = 1'b0; run = 0;
      for (int s = 0; s < 6; s++) begin
        logic sg;
        sg = logic'((pat >> s) & 1);
        run = (run > 0 && sg == last) ? run + 1 : 1;
        last = sg;
        if (run >= THRESH) pol = sg;
        evid(s % 2 == 0, sg);
        chk(regRdData[0] == pol, "R2/R3 sweep status", int'(regRdData[0]), int'(pol));
        @(negedge clk);
        chk(polInverted == pol, "R10 sweep applied", int'(polInverted), int'(pol));
      end
      chkFix(pol, "R9 sweep data");
    end

    // R4 same-cycle strobes: link-pulse sign wins
    doReset();
    evBoth(1'b1, 1'b0);
    evBoth(1'b1, 1'b0);
    chk(regRdData[0] == 1'b1, "R4 lp priority", int'(regRdData[0]), 1);
    evBoth(1'b0, 1'b1);
    evBoth(1'b0, 1'b1);
    chk(regRdData[0] == 1'b0, "R4 lp priority back", int'(regRdData[0]), 0);

    // R7 auto mode ignores bit 0 of a write
    doReset();
    regWr(2'b01);
    chk(regRdData == 2'b00, "R7 auto write", int'(regRdData), 0);
    @(negedge clk);
    chkFix(1'b0, "R7 data");

    // R5 manual writes
    regWr(2'b11);
    chk(regRdData == 2'b11, "R5 manual set", int'(regRdData), 3);
    @(negedge clk);
    chk(polInverted == 1'b1, "R5 applied", int'(polInverted), 1);
    chkFix(1'b1, "R5 data");
    regWr(2'b10);
    chk(regRdData == 2'b10, "R5 manual clear", int'(regRdData), 2);

    // R6 reports ignored in manual mode
    repeat (3) evid(1'b1, 1'b1);
    repeat (3) evid(1'b0, 1'b1);
    chk(regRdData == 2'b10, "R6 manual ignores", int'(regRdData), 2);
    @(negedge clk);
    chkFix(1'b0, "R6 data");

    // R8 manual to auto holds polarity
    regWr(2'b11);
    regWr(2'b01);
    chk(regRdData == 2'b01, "R8 hold after switch", int'(regRdData), 1);
    evid(1'b1, 1'b0);
    chk(regRdData == 2'b01, "R8 one report", int'(regRdData), 1);
    evid(1'b0, 1'b0);
    chk(regRdData == 2'b00, "R8 decided", int'(regRdData), 0);

    // R9 decision during a frame waits for frame end
    doReset();
    rxInFrame = 1'b1;
    evid(1'b1, 1'b1);
    evid(1'b1, 1'b1);
    chk(regRdData[0] == 1'b1, "R9 decided in frame", int'(regRdData[0]), 1);
    repeat (3) @(negedge clk);
    chk(polInverted == 1'b0, "R9 held in frame", int'(polInverted), 0);
    chkFix(1'b0, "R9 data in frame");
    rxInFrame = 1'b0;
    @(negedge clk);
    chk(polInverted == 1'b1, "R9 applied after frame", int'(polInverted), 1);
    chkFix(1'b1, "R9 data after frame");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule